// File: doc/BRIEF.md
# Masked Sprite Compositor

The compositor paints up to 24 sprites, each 16×16 pixels, onto a monochrome frame buffer that already holds a background. The frame buffer is 96×64 pixels. Each byte of the frame buffer holds a vertical strip of 8 pixels in one column.

A `start` pulse launches a pass. The pass walks the sprite attribute table from the highest index down to index 0, so lower-numbered sprites are painted later and end up on top. For each enabled sprite the block does the following:

- It fetches a mask column and a graphic column for each of the 16 sprite columns.
- It applies the flip and invert options.
- It aligns the 16 rows to the 8-row pages of the frame buffer.
- It performs a read-modify-write on every on-screen byte that the sprite actually covers.

All traffic goes through one byte-wide memory port. The port is shared with the frame buffer, the attribute table and the sprite tile data. A read returns data in the cycle after it is issued.

A sprite is placed on a 128×128 plane whose origin lies 16 pixels up and to the left of the screen's top-left corner. A sprite can therefore hang off any edge. Pixels that fall off screen are dropped, and no memory access is made for them.

The controller has eight states:

| State | Action | Next state |
|---|---|---|
| `S_IDLE` | Waits for `start`. | `S_ATTR` |
| `S_ATTR` | Issues four attribute reads and captures the data. | `S_EVAL` |
| `S_EVAL` | Tests the enable flag. | Enabled: `S_COL`. Disabled: the next sprite's `S_ATTR`, or `S_DONE` after sprite 0. |
| `S_COL` | Tests whether the current column lands on screen. | On screen: `S_TILE`. Off screen: the next column, then the next sprite. |
| `S_TILE` | Issues four tile reads. | `S_PAGE` |
| `S_PAGE` | Visits the three page slots a column can touch. If a slot needs work, it issues a frame buffer read. | Read issued: `S_WRITE`. Otherwise: the next slot, then the next column. |
| `S_WRITE` | Writes the merged byte. | The next slot, then the next column. |
| `S_DONE` | Pulses `done`. | `S_IDLE` |

Top module: `sprite_compositor`

## Requirements
- R1: A `start` seen in `S_IDLE` makes the next cycle a read of the attribute entry of sprite 23, at `ATTR_BASE`+92. Sprites are processed from index 23 down to 0, so where sprites overlap, the lower index wins.
- R2: Each sprite has a 4-byte attribute entry at `ATTR_BASE`+4×index. The bytes are:
  - byte 0: X position; bit 7 is ignored.
  - byte 1: Y position; bit 7 is ignored.
  - byte 2: tile index.
  - byte 3: flags, with bit 3 enable, bit 2 invert, bit 1 vertical flip and bit 0 horizontal flip.
- R3: Sprite pixel (c,r) lands at screen x = X−16+c and y = Y−16+r. Screen pixel (x,y) lives in byte `FB_BASE` + (y div 8)×96 + x, at bit y mod 8, where bit 0 is the top row.
- R4: Tile data starts at `spr_base` + tile index×64. Inside it are eight 8-byte blocks in this order: mask left-top, mask left-bottom, graphic left-top, graphic left-bottom, mask right-top, mask right-bottom, graphic right-top, graphic right-bottom. Byte k of a block is column k of that 8×8 quarter, with bit 0 as its top row.
- R5: Each covered pixel becomes (old AND mask) OR (graphic AND NOT mask). A mask bit of 1 keeps the old pixel.
- R6: With invert set, the graphic bits are complemented and the mask is used as stored.
- R7: Horizontal flip mirrors the 16 columns. Vertical flip mirrors the 16 rows.
- R8: A sprite whose enable bit is 0 causes no frame buffer access.
- R9: Pixels outside the 96×64 screen are not written. No write ever leaves the 768-byte frame buffer.
- R10: Every write goes to the address read in the immediately preceding cycle. A read and a write are never issued in the same cycle.
- R11: After reset the outputs are idle. When the pass finishes, `done` is high for exactly one cycle. A `start` that arrives while a pass is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a pass; honoured only when idle |
| spr_base | input | 24 | Base byte address of sprite tile data |
| done | output | 1 | One-cycle pulse at the end of a pass |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The assertions take four things for granted:
- The memory answers every read with data in the very next cycle, with no wait states.
- Nothing else writes the memory during a pass.
- `spr_base` stays constant from `start` to `done`.
- `start` is a single-cycle pulse.

The bench's memory model is a one-cycle synchronous RAM. The bench changes memory contents and `spr_base` only while the block is idle. It raises `start` for one cycle except in the scenario that deliberately pulses it again mid-pass.

// File: rtl/spr_pkg.sv
`timescale 1ns/1ps
package spr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ATTR,
        S_EVAL,
        S_COL,
        S_TILE,
        S_PAGE,
        S_WRITE,
        S_DONE
    } spr_state_e;

    localparam int FLG_HFLIP = 0;
    localparam int FLG_VFLIP = 1;
    localparam int FLG_INV   = 2;
    localparam int FLG_EN    = 3;

    localparam int SPR_DIM   = 16;
    localparam int SLOTS     = 3;

endpackage

// File: rtl/spr_geom.sv
`timescale 1ns/1ps
module spr_geom #(
    parameter int SCR_W     = 96,
    parameter int SCR_PAGES = 8,
    parameter int PLANE_OFS = 16
) (
    input  logic [7:0] pos_x,
    input  logic [7:0] pos_y,
    input  logic [3:0] col,
    input  logic [1:0] slot,
    input  logic       hflip,
    output logic       col_ok,
    output logic [7:0] scr_x,
    output logic       page_ok,
    output logic [7:0] page,
    output logic [2:0] row_off,
    output logic [3:0] src_col
);
    localparam logic [8:0] W9   = 9'(SCR_W);
    localparam logic [8:0] P9   = 9'(SCR_PAGES);
    localparam logic [8:0] OFS9 = 9'(PLANE_OFS);

    logic [8:0] sx_raw;
    logic [8:0] sy_raw;
    logic [8:0] p0;
    logic [8:0] p_raw;

    always_comb begin
        // coordinate bit 7 is dropped: the plane wraps at 128
        sx_raw  = {2'b00, pos_x[6:0]} + {5'b00000, col} - OFS9;
        sy_raw  = {2'b00, pos_y[6:0]} - OFS9;
        p0      = {{3{sy_raw[8]}}, sy_raw[8:3]};
        p_raw   = p0 + {7'b0000000, slot};
        col_ok  = !sx_raw[8] && (sx_raw < W9);
        page_ok = !p_raw[8] && (p_raw < P9);
        scr_x   = sx_raw[7:0];
        page    = p_raw[7:0];
        row_off = sy_raw[2:0];
        src_col = hflip ? ~col : col;
    end
endmodule

// File: rtl/spr_colbuild.sv
`timescale 1ns/1ps
module spr_colbuild (
    input  logic [3:0][7:0] tiles,
    input  logic            vflip,
    input  logic            inv,
    input  logic [2:0]      row_off,
    input  logic [1:0]      slot,
    output logic [7:0]      mbyte,
    output logic [7:0]      gbyte
);
    logic [15:0] mcol, gcol, mv, gv, gi;
    logic [23:0] m24, g24;

    always_comb begin
        mcol = {tiles[1], tiles[0]};
        gcol = {tiles[3], tiles[2]};
        for (int i = 0; i < 16; i++) begin
            mv[i] = vflip ? mcol[15-i] : mcol[i];
            gv[i] = vflip ? gcol[15-i] : gcol[i];
        end
        gi  = gv ^ {16{inv}};
        // rows outside the sprite are transparent (mask bit 1)
        m24 = ~({8'h00, ~mv} << row_off);
        g24 = {8'h00, gi} << row_off;
        case (slot)
            2'd0:    begin mbyte = m24[7:0];   gbyte = g24[7:0];   end
            2'd1:    begin mbyte = m24[15:8];  gbyte = g24[15:8];  end
            default: begin mbyte = m24[23:16]; gbyte = g24[23:16]; end
        endcase
    end
endmodule

// File: rtl/spr_addr.sv
`timescale 1ns/1ps
module spr_addr #(
    parameter int              AW        = 24,
    parameter int              SPR_W     = 5,
    parameter int              SCR_W     = 96,
    parameter logic [AW-1:0]   ATTR_BASE = 'h1300,
    parameter logic [AW-1:0]   FB_BASE   = 'h1000
) (
    input  logic [SPR_W-1:0] spr_idx,
    input  logic [1:0]       fidx,
    input  logic [AW-1:0]    spr_base,
    input  logic [7:0]       tile_idx,
    input  logic [3:0]       src_col,
    input  logic [7:0]       page,
    input  logic [7:0]       scr_x,
    output logic [AW-1:0]    attr_addr,
    output logic [AW-1:0]    tile_addr,
    output logic [AW-1:0]    fb_addr
);
    always_comb begin
        attr_addr = ATTR_BASE + AW'({spr_idx, fidx});
        // fidx: 0 mask top, 1 mask bottom, 2 graphic top, 3 graphic bottom
        tile_addr = spr_base + AW'({tile_idx, src_col[3], fidx, src_col[2:0]});
        fb_addr   = FB_BASE + AW'(page) * AW'(SCR_W) + AW'(scr_x);
    end
endmodule

// File: rtl/sprite_compositor.sv
`timescale 1ns/1ps
module sprite_compositor
    import spr_pkg::*;
#(
    parameter int            AW        = 24,
    parameter int            NUM_SPR   = 24,
    parameter int            SCR_W     = 96,
    parameter int            SCR_PAGES = 8,
    parameter int            PLANE_OFS = 16,
    parameter logic [AW-1:0] ATTR_BASE = 'h1300,
    parameter logic [AW-1:0] FB_BASE   = 'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] spr_base,
    output logic          done,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    localparam int            SPR_W      = $clog2(NUM_SPR);
    localparam logic [SPR_W-1:0] LAST_SPR = SPR_W'(NUM_SPR - 1);
    localparam logic [AW-1:0] FIRST_ATTR = ATTR_BASE + AW'(4 * (NUM_SPR - 1));
    localparam logic [AW-1:0] FB_END     = FB_BASE + AW'(SCR_W * SCR_PAGES);
    localparam logic [3:0]    LAST_COL   = 4'(SPR_DIM - 1);
    localparam logic [1:0]    LAST_SLOT  = 2'(SLOTS - 1);

    spr_state_e       state;
    logic [SPR_W-1:0] spr_q;
    logic [2:0]       fcnt_q;
    logic [3:0]       col_q;
    logic [1:0]       slot_q;
    logic [3:0][7:0]  attr_q;
    logic [3:0][7:0]  tile_q;
    logic [1:0]       cap_idx;

    logic             col_ok, page_ok;
    logic [7:0]       scr_x, page;
    logic [2:0]       row_off;
    logic [3:0]       src_col;
    logic [7:0]       mbyte, gbyte;
    logic [AW-1:0]    attr_addr, tile_addr, fb_addr;
    logic             need_rmw;

    assign cap_idx  = fcnt_q[1:0] - 2'd1;
    assign need_rmw = page_ok && (mbyte != 8'hFF);

    spr_geom #(
        .SCR_W(SCR_W), .SCR_PAGES(SCR_PAGES), .PLANE_OFS(PLANE_OFS)
    ) u_geom (
        .pos_x(attr_q[0]), .pos_y(attr_q[1]), .col(col_q), .slot(slot_q),
        .hflip(attr_q[3][FLG_HFLIP]), .col_ok(col_ok), .scr_x(scr_x),
        .page_ok(page_ok), .page(page), .row_off(row_off), .src_col(src_col)
    );

    spr_colbuild u_col (
        .tiles(tile_q), .vflip(attr_q[3][FLG_VFLIP]), .inv(attr_q[3][FLG_INV]),
        .row_off(row_off), .slot(slot_q), .mbyte(mbyte), .gbyte(gbyte)
    );

    spr_addr #(
        .AW(AW), .SPR_W(SPR_W), .SCR_W(SCR_W),
        .ATTR_BASE(ATTR_BASE), .FB_BASE(FB_BASE)
    ) u_addr (
        .spr_idx(spr_q), .fidx(fcnt_q[1:0]), .spr_base(spr_base),
        .tile_idx(attr_q[2]), .src_col(src_col), .page(page), .scr_x(scr_x),
        .attr_addr(attr_addr), .tile_addr(tile_addr), .fb_addr(fb_addr)
    );

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            spr_q  <= '0;
            fcnt_q <= '0;
            col_q  <= '0;
            slot_q <= '0;
            attr_q <= '0;
            tile_q <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state  <= S_ATTR;
                        spr_q  <= LAST_SPR;
                        fcnt_q <= '0;
                    end
                end
                S_ATTR: begin
                    if (fcnt_q != 3'd0) attr_q[cap_idx] <= mem_rdata;
                    if (fcnt_q == 3'd4) state <= S_EVAL;
                    else                fcnt_q <= fcnt_q + 3'd1;
                end
                S_EVAL: begin
                    if (attr_q[3][FLG_EN]) begin
                        state <= S_COL;
                        col_q <= '0;
                    end else if (spr_q == '0) begin
                        state <= S_DONE;
                    end else begin
                        spr_q  <= spr_q - 1'b1;
                        fcnt_q <= '0;
                        state  <= S_ATTR;
                    end
                end
                S_COL: begin
                    if (col_ok) begin
                        state  <= S_TILE;
                        fcnt_q <= '0;
                    end else if (col_q != LAST_COL) begin
                        col_q <= col_q + 4'd1;
                    end else if (spr_q == '0) begin
                        state <= S_DONE;
                    end else begin
                        spr_q  <= spr_q - 1'b1;
                        fcnt_q <= '0;
                        state  <= S_ATTR;
                    end
                end
                S_TILE: begin
                    if (fcnt_q != 3'd0) tile_q[cap_idx] <= mem_rdata;
                    if (fcnt_q == 3'd4) begin
                        state  <= S_PAGE;
                        slot_q <= '0;
                    end else begin
                        fcnt_q <= fcnt_q + 3'd1;
                    end
                end
                S_PAGE, S_WRITE: begin
                    if (state == S_PAGE && need_rmw) begin
                        state <= S_WRITE;
                    end else if (slot_q != LAST_SLOT) begin
                        slot_q <= slot_q + 2'd1;
                        state  <= S_PAGE;
                    end else if (col_q != LAST_COL) begin
                        col_q <= col_q + 4'd1;
                        state <= S_COL;
                    end else if (spr_q == '0) begin
                        state <= S_DONE;
                    end else begin
                        spr_q  <= spr_q - 1'b1;
                        fcnt_q <= '0;
                        state  <= S_ATTR;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs from state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state)
            S_ATTR: if (fcnt_q != 3'd4) begin
                mem_rd   = 1'b1;
                mem_addr = attr_addr;
            end
            S_TILE: if (fcnt_q != 3'd4) begin
                mem_rd   = 1'b1;
                mem_addr = tile_addr;
            end
            S_PAGE: if (need_rmw) begin
                mem_rd   = 1'b1;
                mem_addr = fb_addr;
            end
            S_WRITE: begin
                mem_wr    = 1'b1;
                mem_addr  = fb_addr;
                mem_wdata = (mem_rdata & mbyte) | (gbyte & ~mbyte);
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    a_r1_first_attr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (mem_rd && mem_addr == FIRST_ATTR));

    a_r9_write_in_fb: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr >= FB_BASE && mem_addr < FB_END));

    a_r10_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r10_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && $past(mem_addr) == mem_addr));

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_DONE && start) |=> (state != S_IDLE || $past(state) == S_DONE));

endmodule

// File: tb/sprite_compositor_bench.sv
`timescale 1ns/1ps
module sprite_compositor_bench;
    localparam int FB   = 'h1000;
    localparam int ATTR = 'h1300;
    localparam int TBAS = 'h2000;
    localparam int MSZ  = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] spr_base = 24'(TBAS);
    logic        done, mem_rd, mem_wr;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    logic [7:0]  mem [0:MSZ-1];
    logic [7:0]  exp_fb [0:767];

    int n_tests = 0, n_fail = 0;
    int wr_cnt = 0, viol = 0, oob = 0;
    logic        prev_rd = 1'b0;
    logic [23:0] prev_addr = '0;

    always #2.5 clk = ~clk;

    sprite_compositor u_sprite_compositor (
        .clk(clk), .rst_n(rst_n), .start(start), .spr_base(spr_base),
        .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // one-cycle synchronous memory
    always @(posedge clk) begin
        if (mem_rd && mem_addr < 24'(MSZ)) mem_rdata <= mem[mem_addr[13:0]];
        if (mem_wr && mem_addr < 24'(MSZ)) mem[mem_addr[13:0]] <= mem_wdata;
    end

    // port monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if ((mem_rd || mem_wr) && mem_addr >= 24'(MSZ)) oob++;
            if (mem_wr) begin
                wr_cnt++;
                if (mem_addr < 24'(FB) || mem_addr >= 24'(FB + 768)) oob++;
                if (!prev_rd || prev_addr != mem_addr) viol++;
            end
            if (mem_rd && mem_wr) viol++;
            prev_rd   <= mem_rd;
            prev_addr <= mem_addr;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic clear_attrs();
        for (int i = 0; i < 96; i++) mem[ATTR + i] = 8'h00;
    endtask

    task automatic rand_fb();
        for (int i = 0; i < 768; i++) mem[FB + i] = 8'($urandom);
    endtask

    task automatic set_spr(input int s, input int x, input int y, input int idx, input int fl);
        mem[ATTR + 4*s]     = 8'(x);
        mem[ATTR + 4*s + 1] = 8'(y);
        mem[ATTR + 4*s + 2] = 8'(idx);
        mem[ATTR + 4*s + 3] = 8'(fl);
    endtask

    // solid=1: mask 0 everywhere, graphic = g; else random data
    task automatic fill_tile(input int idx, input bit solid, input logic [7:0] g);
        for (int b = 0; b < 64; b++) begin
            if (solid) mem[TBAS + idx*64 + b] = ((b / 8) % 4 >= 2) ? g : 8'h00;
            else       mem[TBAS + idx*64 + b] = 8'($urandom);
        end
    endtask

    task automatic compute_expected();
        for (int i = 0; i < 768; i++) exp_fb[i] = mem[FB + i];
        for (int s = 23; s >= 0; s--) begin
            int px, py, idx;
            logic [7:0] fl;
            px  = mem[ATTR + 4*s] & 127;
            py  = mem[ATTR + 4*s + 1] & 127;
            idx = mem[ATTR + 4*s + 2];
            fl  = mem[ATTR + 4*s + 3];
            if (fl[3]) begin
                for (int r = 0; r < 16; r++) begin
                    for (int c = 0; c < 16; c++) begin
                        int sc, sr, t, ta, x, y;
                        logic [7:0] mt, gt;
                        logic mb, gb;
                        sc = fl[0] ? 15 - c : c;
                        sr = fl[1] ? 15 - r : r;
                        t  = (sc >= 8 ? 4 : 0) + (sr >= 8 ? 1 : 0);
                        ta = TBAS + idx*64 + t*8 + sc % 8;
                        mt = mem[ta];
                        gt = mem[ta + 16];
                        mb = mt[sr % 8];
                        gb = gt[sr % 8] ^ fl[2];
                        x  = px - 16 + c;
                        y  = py - 16 + r;
                        if (x >= 0 && x < 96 && y >= 0 && y < 64 && !mb)
                            exp_fb[(y/8)*96 + x][y % 8] = gb;
                    end
                end
            end
        end
    endtask

    task automatic pulse_and_wait();
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic compare_fb(input string req);
        int bad, fa, fe, fi;
        bad = 0; fa = 0; fe = 0; fi = 0;
        for (int i = 0; i < 768; i++) begin
            if (mem[FB + i] !== exp_fb[i]) begin
                if (bad == 0) begin fa = mem[FB + i]; fe = exp_fb[i]; fi = i; end
                bad++;
            end
        end
        if (bad != 0) $display("  mismatch at fb offset %0d (%0d bytes)", fi, bad);
        check(bad == 0, req, fa, fe);
    endtask

    task automatic run_model(input string req);
        compute_expected();
        pulse_and_wait();
        @(negedge clk);
        compare_fb(req);
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R11 reset done", int'(done), 0);
        check(mem_rd == 1'b0, "R11 reset rd", int'(mem_rd), 0);
        check(mem_wr == 1'b0, "R11 reset wr", int'(mem_wr), 0);
    endtask

    task automatic t_single();
        logic [7:0] left;
        clear_attrs(); rand_fb();
        fill_tile(2, 1'b1, 8'hFF);
        set_spr(7, 40, 32, 2, 8'h08);
        left = mem[FB + 2*96 + 23];
        run_model("R5 solid sprite");
        check(mem[FB + 2*96 + 24] == 8'hFF, "R3 placement", mem[FB + 2*96 + 24], 8'hFF);
        check(mem[FB + 2*96 + 23] == left, "R3 neighbour untouched", mem[FB + 2*96 + 23], left);
        clear_attrs(); rand_fb();
        fill_tile(9, 1'b0, 8'h00);
        set_spr(11, 40, 32, 9, 8'h08);
        run_model("R4 random tile aligned");
    endtask

    task automatic t_invert();
        clear_attrs(); rand_fb();
        fill_tile(3, 1'b0, 8'h00);
        set_spr(2, 60, 37, 3, 8'h0C);
        run_model("R6 invert unaligned");
    endtask

    task automatic t_flip();
        clear_attrs(); rand_fb();
        fill_tile(6, 1'b0, 8'h00);
        set_spr(4, 50, 21, 6, 8'h0B);
        set_spr(9, 20, 45, 6, 8'h09);
        set_spr(15, 80, 30, 6, 8'h0A);
        run_model("R7 flips");
    endtask

    task automatic t_overlap();
        clear_attrs(); rand_fb();
        fill_tile(4, 1'b1, 8'h00);
        fill_tile(5, 1'b1, 8'hFF);
        set_spr(0, 40, 32, 4, 8'h08);
        set_spr(5, 40, 32, 5, 8'h08);
        run_model("R1 overlap model");
        check(mem[FB + 2*96 + 30] == 8'h00, "R1 sprite 0 on top", mem[FB + 2*96 + 30], 0);
    endtask

    task automatic t_disabled();
        int w0;
        clear_attrs(); rand_fb();
        fill_tile(7, 1'b1, 8'hAA);
        set_spr(3, 40, 32, 7, 8'h07);
        set_spr(20, 30, 30, 7, 8'h00);
        w0 = wr_cnt;
        run_model("R8 disabled fb unchanged");
        check(wr_cnt == w0, "R8 no writes", wr_cnt - w0, 0);
    endtask

    task automatic t_clip();
        int o0;
        clear_attrs(); rand_fb();
        for (int i = 10; i < 16; i++) fill_tile(i, 1'b0, 8'h00);
        set_spr(1, 0, 0, 10, 8'h08);
        set_spr(2, 127, 127, 11, 8'h08);
        set_spr(3, 8'hA8, 8'hB0, 12, 8'h08);
        set_spr(4, 5, 70, 13, 8'h09);
        set_spr(5, 110, 3, 14, 8'h0E);
        set_spr(6, 100, 78, 15, 8'h08);
        o0 = oob;
        run_model("R9 R2 clipping and wrap");
        check(oob == o0, "R9 no access outside fb", oob - o0, 0);
    endtask

    task automatic t_first_read();
        clear_attrs();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(mem_rd && mem_addr == 24'(ATTR + 92), "R1 first attr read",
              int'(mem_addr), ATTR + 92);
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_busy_start();
        bit extra;
        clear_attrs(); rand_fb();
        fill_tile(20, 1'b0, 8'h00);
        set_spr(12, 33, 44, 20, 8'h08);
        compute_expected();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(done == 1'b0, "R11 done one cycle", int'(done), 0);
        extra = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (mem_rd || done) extra = 1'b1;
        end
        check(!extra, "R11 start while busy ignored", int'(extra), 0);
        compare_fb("R11 busy run result");
    endtask

    initial begin
        for (int i = 0; i < MSZ; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_single();
        t_invert();
        t_flip();
        t_overlap();
        t_disabled();
        t_clip();
        t_first_read();
        t_busy_start();
        check(viol == 0, "R10 read-before-write", viol, 0);
        check(oob == 0, "R9 total out-of-range", oob, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule